// File: doc/BRIEF.md
# Initiator Command and Interrupt Status Core

This block is the command and status core of a SCSI-style initiator controller. Software writes an 8-bit command byte. Bit 7 of that byte requests DMA mode, and bits 6:0 pick the operation. The core then updates a status register, an interrupt-cause register and a sequence-step register, and it drives a level interrupt line. Target behaviour is reduced to two inputs: a presence mask indexed by the selected bus ID, and a signed transfer length. A positive length means data-in, a negative length means data-out, and zero means no data phase.

Software polls the status register or waits for the interrupt. It then reads the cause register, and that read acknowledges the event. A configuration bit can suppress the interrupt that a bus-reset command would raise. A chip-reset command returns every register to its power-up value.

Top module: `scsi_cmd_core`

## Requirements
- R1: After reset, status (address 4), cause (address 5) and sequence step (address 6) read 0, configuration-1 (address 8) reads 0x07, address 0xE reads 0x04, and the interrupt is low.
- R2: A command write (address 3) reads back as written. Its bit 7 drives dma_o. When bit 7 is set, the counter bytes written at addresses 0 and 1 are copied into the counter that reads back at those addresses.
- R3: A read of address 5 returns the cause value held before the read. The same read clears the cause, clears status bit 4, sets the sequence step to 4 and lowers the interrupt.
- R4: Status bit 7 always equals irq_o.
- R5: Bus reset (opcode 0x03) sets the cause to 0x80. It raises the interrupt only when configuration-1 bit 6 is clear.
- R6: A select (opcode 0x41, 0x42 or 0x43) whose target is absent sets status bits 6:0 to 0, cause to 0x20 and step to 0, and raises the interrupt. The target is the one named by address 4 bits 2:0 of the bus-ID register, looked up in tgt_present_i.
- R7: Select with attention and stop (0x43) to a present target sets status bits 6:0 to 0x12, cause to 0x18 and step to 4, and raises the interrupt.
- R8: Select 0x41 or 0x42 to a present target sets cause to 0x18 and step to 4, and raises the interrupt. Status bits 6:0 depend on tgt_len_i: 0x11 if it is positive, 0x10 if it is negative, and unchanged if it is zero.
- R9: Message accepted (0x12) sets cause to 0x20, clears the step and the flags register (address 7), and raises the interrupt.
- R10: Transfer pad (0x18) sets status bits 6:0 to 0x10, cause to 0x08 and step to 0, and leaves the interrupt as it was.
- R11: Flush (0x01) sets cause to 0x08 and clears the step and the flags register, without raising the interrupt.
- R12: Chip reset (0x02) returns every register, dma_o and the interrupt to their R1 values. The counter reads 0 afterwards.
- R13: An unlisted opcode changes nothing except the command register, and err_o is high for exactly the following cycle.
- R14: Command-complete sequence (0x11) sets cause to 0x08 and raises the interrupt. Without DMA it sets status bits 2:0 to 7 and the flags register to 2. With DMA it sets status bits 6:0 to 0x17 and the step to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on address 5) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational while rd_en_i is high |
| tgt_present_i | input | 8 | Device-present mask, indexed by bus ID |
| tgt_len_i | input | 16 | Two's-complement transfer length of the target |
| irq_o | output | 1 | Level interrupt |
| dma_o | output | 1 | DMA mode of the last accepted command |
| err_o | output | 1 | One-cycle flag for an unlisted opcode |

## Verification
The assertions assume that a read and a write never fall in the same cycle. They also assume that tgt_present_i and tgt_len_i are stable during the cycle in which a command is written. The cause-clearing and interrupt properties are therefore qualified by the absence of a write. The bench's access tasks perform exactly one read or one write per cycle, and they change target inputs only between accesses. Every scenario ends by reading the cause register, so each test starts from a lowered interrupt.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_TC0   = 4'h0;
  localparam logic [ADDR_W-1:0] A_TC1   = 4'h1;
  localparam logic [ADDR_W-1:0] A_CMD   = 4'h3;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'h4;  // write side: bus ID
  localparam logic [ADDR_W-1:0] A_CAUSE = 4'h5;
  localparam logic [ADDR_W-1:0] A_SEQ   = 4'h6;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'h7;
  localparam logic [ADDR_W-1:0] A_CFG1  = 4'h8;
  localparam logic [ADDR_W-1:0] A_CFG2  = 4'hB;
  localparam logic [ADDR_W-1:0] A_CFG3  = 4'hC;
  localparam logic [ADDR_W-1:0] A_ID    = 4'hE;

  localparam logic [DW-1:0] CFG1_RST = 8'h07;
  localparam logic [DW-1:0] CHIP_ID  = 8'h04;
  localparam int unsigned   CFG1_MASK_BIT = 6;

  localparam logic [DW-1:0] C_FC  = 8'h08;
  localparam logic [DW-1:0] C_BS  = 8'h10;
  localparam logic [DW-1:0] C_DC  = 8'h20;
  localparam logic [DW-1:0] C_RST = 8'h80;

  localparam int unsigned ST_TC = 4;

  typedef enum logic [3:0] {
    OP_NOP, OP_FLUSH, OP_CHIP_RST, OP_BUS_RST, OP_XFER, OP_CMPL_SEQ,
    OP_MSG_OK, OP_PAD, OP_ATN, OP_SEL, OP_SEL_ATN, OP_SEL_STOP,
    OP_EN_SEL, OP_BAD
  } op_e;
endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_cmd_pkg::*;
(
  input  logic [6:0] opcode_i,
  output op_e        op_o,
  output logic       is_sel_o,
  output logic       valid_o
);
  always_comb begin
    unique case (opcode_i)
      7'h00:   op_o = OP_NOP;
      7'h01:   op_o = OP_FLUSH;
      7'h02:   op_o = OP_CHIP_RST;
      7'h03:   op_o = OP_BUS_RST;
      7'h10:   op_o = OP_XFER;
      7'h11:   op_o = OP_CMPL_SEQ;
      7'h12:   op_o = OP_MSG_OK;
      7'h18:   op_o = OP_PAD;
      7'h1A:   op_o = OP_ATN;
      7'h41:   op_o = OP_SEL;
      7'h42:   op_o = OP_SEL_ATN;
      7'h43:   op_o = OP_SEL_STOP;
      7'h44:   op_o = OP_EN_SEL;
      default: op_o = OP_BAD;
    endcase
  end

  assign is_sel_o = (op_o == OP_SEL) || (op_o == OP_SEL_ATN) || (op_o == OP_SEL_STOP);
  assign valid_o  = (op_o != OP_BAD);
endmodule

// File: rtl/scsi_cfg_regs.sv
module scsi_cfg_regs
  import scsi_cmd_pkg::*;
#(
  parameter int unsigned TCW     = 16,
  parameter int unsigned BUSID_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     cfg1_o,
  output logic [DW-1:0]     cfg2_o,
  output logic [DW-1:0]     cfg3_o,
  output logic [BUSID_W-1:0] busid_o,
  output logic [TCW-1:0]    tc_load_o
);
  localparam int unsigned TC_BYTES = TCW / DW;

  // counter reload bytes live at the lowest addresses
  for (genvar k = 0; k < TC_BYTES; k++) begin : g_tc
    logic [DW-1:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   b_q <= '0;
      else if (soft_rst_i)                           b_q <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(k))      b_q <= wdata_i;
    end
    assign tc_load_o[k*DW +: DW] = b_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_o  <= CFG1_RST;
      cfg2_o  <= '0;
      cfg3_o  <= '0;
      busid_o <= '0;
    end else if (soft_rst_i) begin
      cfg1_o  <= CFG1_RST;
      cfg2_o  <= '0;
      cfg3_o  <= '0;
      busid_o <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_CFG1:  cfg1_o  <= wdata_i;
        A_CFG2:  cfg2_o  <= wdata_i;
        A_CFG3:  cfg3_o  <= wdata_i;
        A_STAT:  busid_o <= wdata_i[BUSID_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scsi_irq_ctrl.sv
module scsi_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic raise_i,
  input  logic lower_i,
  output logic irq_o
);
  // clear beats raise beats lower
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_o <= 1'b0;
    else if (clear_i) irq_o <= 1'b0;
    else if (raise_i) irq_o <= 1'b1;
    else if (lower_i) irq_o <= 1'b0;
  end

  p_raise_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_i && !clear_i) |=> irq_o);

  p_lower_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lower_i && !raise_i) |=> !irq_o);
endmodule

// File: rtl/scsi_cmd_core.sv
module scsi_cmd_core
  import scsi_cmd_pkg::*;
#(
  parameter int unsigned BUSID_W = 3,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned TCW     = 16,
  localparam int unsigned N_TGT  = 1 << BUSID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [N_TGT-1:0]  tgt_present_i,
  input  logic [LEN_W-1:0]  tgt_len_i,
  output logic              irq_o,
  output logic              dma_o,
  output logic              err_o
);
  localparam logic [2:0] SEQ_CMD = 3'd4;

  op_e  op;
  logic is_sel, op_valid;
  logic cmd_wr, cause_rd, soft_rst, tgt_here, len_neg, len_zero;
  logic raise;

  logic [DW-1:0]      cfg1, cfg2, cfg3;
  logic [BUSID_W-1:0] busid;
  logic [TCW-1:0]     tc_load, tc_q;

  logic [DW-1:0] cmd_q, cause_q, flags_q;
  logic [6:0]    stat_q;
  logic [2:0]    seq_q;

  scsi_cmd_decode u_dec (
    .opcode_i (wdata_i[6:0]),
    .op_o     (op),
    .is_sel_o (is_sel),
    .valid_o  (op_valid)
  );

  assign cmd_wr   = wr_en_i && (addr_i == A_CMD);
  assign cause_rd = rd_en_i && (addr_i == A_CAUSE);
  assign soft_rst = cmd_wr && (op == OP_CHIP_RST);
  assign tgt_here = tgt_present_i[busid];
  assign len_neg  = tgt_len_i[LEN_W-1];
  assign len_zero = (tgt_len_i == '0);

  scsi_cfg_regs #(.TCW(TCW), .BUSID_W(BUSID_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cfg1_o     (cfg1),
    .cfg2_o     (cfg2),
    .cfg3_o     (cfg3),
    .busid_o    (busid),
    .tc_load_o  (tc_load)
  );

  always_comb begin
    raise = 1'b0;
    if (cmd_wr) begin
      unique case (op)
        OP_BUS_RST:                  raise = !cfg1[CFG1_MASK_BIT];
        OP_CMPL_SEQ, OP_MSG_OK:      raise = 1'b1;
        OP_SEL, OP_SEL_ATN, OP_SEL_STOP: raise = 1'b1;
        default:                     raise = 1'b0;
      endcase
    end
  end

  scsi_irq_ctrl u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (soft_rst),
    .raise_i (raise),
    .lower_i (cause_rd),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0; cause_q <= '0; flags_q <= '0; stat_q <= '0;
      seq_q <= '0; tc_q <= '0; dma_o <= 1'b0; err_o <= 1'b0;
    end else if (soft_rst) begin
      cmd_q <= '0; cause_q <= '0; flags_q <= '0; stat_q <= '0;
      seq_q <= '0; tc_q <= '0; dma_o <= 1'b0; err_o <= 1'b0;
    end else begin
      err_o <= 1'b0;
      // acknowledge first; a command in the same cycle overrides
      if (cause_rd) begin
        cause_q       <= '0;
        stat_q[ST_TC] <= 1'b0;
        seq_q         <= SEQ_CMD;
      end
      if (wr_en_i && (addr_i == A_TC0 || addr_i == A_TC1))
        stat_q[ST_TC] <= 1'b0;
      if (cmd_wr) begin
        cmd_q <= wdata_i;
        if (!op_valid) begin
          err_o <= 1'b1;
        end else begin
          dma_o <= wdata_i[7];
          if (wdata_i[7]) tc_q <= tc_load;
          unique case (op)
            OP_FLUSH: begin
              cause_q <= C_FC; seq_q <= '0; flags_q <= '0;
            end
            OP_BUS_RST: cause_q <= C_RST;
            OP_XFER: if (wdata_i[7]) stat_q[ST_TC] <= 1'b0;
            OP_CMPL_SEQ: begin
              cause_q <= C_FC;
              if (wdata_i[7]) begin
                stat_q <= 7'h17;
                seq_q  <= SEQ_CMD;
              end else begin
                stat_q[2:0] <= 3'b111;
                flags_q     <= 8'd2;
              end
            end
            OP_MSG_OK: begin
              cause_q <= C_DC; seq_q <= '0; flags_q <= '0;
            end
            OP_PAD: begin
              stat_q <= 7'h10; cause_q <= C_FC; seq_q <= '0;
            end
            OP_SEL, OP_SEL_ATN, OP_SEL_STOP: begin
              if (!tgt_here) begin
                stat_q  <= '0;
                cause_q <= C_DC;
                seq_q   <= '0;
              end else begin
                cause_q <= C_BS | C_FC;
                seq_q   <= SEQ_CMD;
                if (op == OP_SEL_STOP)
                  stat_q <= 7'h12;
                else if (!len_zero)
                  stat_q <= {2'b00, 1'b1, 3'b000, !len_neg};
              end
            end
            OP_EN_SEL: cause_q <= '0;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_TC0:   rdata_o = tc_q[DW-1:0];
        A_TC1:   rdata_o = tc_q[2*DW-1:DW];
        A_CMD:   rdata_o = cmd_q;
        A_STAT:  rdata_o = {irq_o, stat_q};
        A_CAUSE: rdata_o = cause_q;
        A_SEQ:   rdata_o = {5'b0, seq_q};
        A_FLAGS: rdata_o = flags_q;
        A_CFG1:  rdata_o = cfg1;
        A_CFG2:  rdata_o = cfg2;
        A_CFG3:  rdata_o = cfg3;
        A_ID:    rdata_o = CHIP_ID;
        default: rdata_o = '0;
      endcase
    end
  end

  p_rd_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_rd && !wr_en_i) |=> (cause_q == '0 && seq_q == SEQ_CMD && !stat_q[ST_TC] && !irq_o));

  p_busrst_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && op == OP_BUS_RST && cfg1[CFG1_MASK_BIT] && !irq_o) |=> (!irq_o && cause_q == C_RST));

  p_sel_absent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && is_sel && !tgt_here) |=> (cause_q == C_DC && seq_q == '0 && irq_o));

  p_pad_keeps_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && op == OP_PAD && !cause_rd) |=> (irq_o == $past(irq_o)));

  p_err_source_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cmd_wr && !op_valid));

  p_err_state_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !op_valid && !cause_rd) |=> ($stable(cause_q) && $stable(seq_q) && $stable(stat_q)));
endmodule

// File: tb/scsi_cmd_core_test.sv
`timescale 1ns/1ps
module scsi_cmd_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  present = 8'h01;
  logic [15:0] len = '0;
  logic        irq, dma, err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scsi_cmd_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tgt_present_i(present), .tgt_len_i(len),
    .irq_o(irq), .dma_o(dma), .err_o(err)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rchk(string req, logic [3:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rchk("R1 status", 4'h4, 8'h00);
    rchk("R1 cause", 4'h5, 8'h00);
    rchk("R1 cfg1", 4'h8, 8'h07);
    rchk("R1 id", 4'hE, 8'h04);
  endtask

  task automatic t_dma;
    wr(4'h0, 8'h34); wr(4'h1, 8'h12);
    wr(4'h3, 8'h80);
    chk("R2 dma on", {7'b0, dma}, 8'h01);
    rchk("R2 tc lo", 4'h0, 8'h34);
    rchk("R2 tc hi", 4'h1, 8'h12);
    rchk("R2 cmd", 4'h3, 8'h80);
    wr(4'h3, 8'h00);
    chk("R2 dma off", {7'b0, dma}, 8'h00);
  endtask

  task automatic t_busrst;
    wr(4'h3, 8'h03);
    chk("R5 irq", {7'b0, irq}, 8'h01);
    rchk("R4 mirror", 4'h4, 8'h80);
    rchk("R3 old cause", 4'h5, 8'h80);
    chk("R3 irq low", {7'b0, irq}, 8'h00);
    rchk("R3 cause cleared", 4'h5, 8'h00);
    rchk("R3 step", 4'h6, 8'h04);
    wr(4'h8, 8'h47);
    wr(4'h3, 8'h03);
    chk("R5 masked", {7'b0, irq}, 8'h00);
    rchk("R5 cause", 4'h5, 8'h80);
    wr(4'h8, 8'h07);
  endtask

  task automatic t_sel_absent;
    wr(4'h4, 8'h02);
    wr(4'h3, 8'h42);
    chk("R6 irq", {7'b0, irq}, 8'h01);
    rchk("R6 status", 4'h4, 8'h80);
    rchk("R6 step", 4'h6, 8'h00);
    rchk("R6 cause", 4'h5, 8'h20);
    wr(4'h4, 8'h00);
  endtask

  task automatic t_sel_stop;
    wr(4'h3, 8'h43);
    rchk("R7 status", 4'h4, 8'h92);
    rchk("R7 step", 4'h6, 8'h04);
    rchk("R7 cause", 4'h5, 8'h18);
    rchk("R3 tc cleared", 4'h4, 8'h02);
  endtask

  task automatic t_sel;
    len = 16'd5;
    wr(4'h3, 8'h41);
    rchk("R8 data in", 4'h4, 8'h91);
    rchk("R8 cause", 4'h5, 8'h18);
    len = 16'hFFFD;
    wr(4'h3, 8'h42);
    rchk("R8 data out", 4'h4, 8'h90);
    rchk("R8 cause", 4'h5, 8'h18);
    len = 16'd0;
    wr(4'h3, 8'h41);
    rchk("R8 no data", 4'h4, 8'h80);
    rchk("R8 step", 4'h6, 8'h04);
    rchk("R8 cause", 4'h5, 8'h18);
  endtask

  task automatic t_iccs_msg;
    wr(4'h3, 8'h11);
    rchk("R14 pio status", 4'h4, 8'h87);
    rchk("R14 pio flags", 4'h7, 8'h02);
    rchk("R14 cause", 4'h5, 8'h08);
    wr(4'h3, 8'h12);
    chk("R9 irq", {7'b0, irq}, 8'h01);
    rchk("R9 flags", 4'h7, 8'h00);
    rchk("R9 step", 4'h6, 8'h00);
    rchk("R9 cause", 4'h5, 8'h20);
    wr(4'h3, 8'h91);
    rchk("R14 dma status", 4'h4, 8'h97);
    rchk("R14 dma step", 4'h6, 8'h04);
    rchk("R14 cause", 4'h5, 8'h08);
  endtask

  task automatic t_pad;
    wr(4'h3, 8'h18);
    chk("R10 no irq", {7'b0, irq}, 8'h00);
    rchk("R10 status", 4'h4, 8'h10);
    rchk("R10 step", 4'h6, 8'h00);
    rchk("R10 cause", 4'h5, 8'h08);
    wr(4'h3, 8'h03);
    wr(4'h3, 8'h18);
    chk("R10 irq kept", {7'b0, irq}, 8'h01);
    rchk("R10 status R4", 4'h4, 8'h90);
    rchk("R10 cause", 4'h5, 8'h08);
  endtask

  task automatic t_flush;
    wr(4'h3, 8'h11);
    rchk("R11 setup", 4'h5, 8'h08);
    wr(4'h3, 8'h01);
    chk("R11 no irq", {7'b0, irq}, 8'h00);
    rchk("R11 flags", 4'h7, 8'h00);
    rchk("R11 step", 4'h6, 8'h00);
    rchk("R11 cause", 4'h5, 8'h08);
  endtask

  task automatic t_bad;
    wr(4'h3, 8'h03);
    chk("R13 pre", {7'b0, err}, 8'h00);
    wr(4'h3, 8'h05);
    chk("R13 err pulse", {7'b0, err}, 8'h01);
    @(negedge clk);
    chk("R13 err drops", {7'b0, err}, 8'h00);
    rchk("R13 cmd", 4'h3, 8'h05);
    chk("R13 irq kept", {7'b0, irq}, 8'h01);
    rchk("R13 step kept", 4'h6, 8'h04);
    rchk("R13 cause kept", 4'h5, 8'h80);
  endtask

  task automatic t_chiprst;
    wr(4'h3, 8'h11);
    wr(4'h3, 8'h91);
    wr(4'h8, 8'h47);
    chk("R12 pre", {6'b0, irq, dma}, 8'h03);
    wr(4'h3, 8'h02);
    chk("R12 irq dma", {6'b0, irq, dma}, 8'h00);
    rchk("R12 cfg1", 4'h8, 8'h07);
    rchk("R12 status", 4'h4, 8'h00);
    rchk("R12 cmd", 4'h3, 8'h00);
    rchk("R12 step", 4'h6, 8'h00);
    rchk("R12 flags", 4'h7, 8'h00);
    rchk("R12 tc", 4'h0, 8'h00);
    rchk("R12 cause", 4'h5, 8'h00);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_dma();
    t_busrst();
    t_sel_absent();
    t_sel_stop();
    t_sel();
    t_iccs_msg();
    t_pad();
    t_flush();
    t_bad();
    t_chiprst();
    done = 1;
    summary();
  end
endmodule